// File: doc/BRIEF.md
# Paged Display Memory Host Port

This block sits between a host processor's parallel bus and a bit-mapped display memory of 256 columns by 65 lines. The lines are grouped into eight full pages of eight lines, stored one byte per column, plus a ninth indicator page that keeps a single bit per column. The host selects a page and a column with command writes. It then streams bytes in or out, and every data access moves the column pointer one step forward.

A mode input picks the bus flavour. In one flavour the host uses separate active-low read and write strobes. In the other it uses an active-high enable qualified by a read/write level. In both, a data/command select line splits accesses into four kinds: data read, data write, status read and command write. An access completes when its strobe ends. Reads are pipelined through a holding register. The byte on the bus during a data read is the one fetched by the previous data read. So the first read after any address change or data write returns stale data, and the addressed byte arrives on the second read.

The sequencing is a three-state machine. `ST_IDLE` waits for a selected strobe and takes the transition *start* to `ST_ACTIVE`. `ST_ACTIVE` tracks the bus while the strobe is held. It takes *abandon* back to `ST_IDLE` if the chip is deselected, or *finish* to `ST_COMMIT` when the strobe ends. `ST_COMMIT` performs the memory, holder, pointer or command update in one cycle and takes *retire* back to `ST_IDLE`.

Top module: `lcdp_access_port`

## Requirements
- R1: With `bus68` low the strobes are `rd_e` as an active-low read and `wr_rw` as an active-low write. With `bus68` high, `rd_e` is an active-high enable and `wr_rw` high means read, low means write.
- R2: The four access kinds are data read (`dc`=1, read), data write (`dc`=1, write), status read (`dc`=0, read) and command write (`dc`=0, write).
- R3: The port is selected only when `cs1_n` is 0 and `cs2` is 1. When it is not selected, `dout_en` stays 0 and strobes change neither memory nor addresses.
- R4: Write data is taken as it stands at the end of the strobe: the rising edge of the write strobe in the separate-strobe mode, or the falling edge of the enable in the enable mode.
- R5: A data read drives the holding register onto `dout` and then reloads the register from the current address. After an address change or a data write, the first read returns the old holder value and the second returns the addressed byte. The holder resets to 00h.
- R6: Each data read or data write raises the column by one. At FFh the column stays at FFh, and further accesses keep using FFh.
- R7: Column movement never changes the page. The page changes only through the page command.
- R8: On page 8 only data bit 0 is stored. A write there drops bits 7..1, and a read from there yields zeros in bits 7..1.
- R9: A status read returns the busy flag in bit 7 and zeros in bits 6..0. Busy is 1 only during the commit cycle, so an idle status read returns 00h.
- R10: The command byte 1011pppp sets the page to pppp if pppp is 8 or less and is ignored otherwise. 0001hhhh loads column bits 7..4, and 0000llll loads column bits 3..0. Other command bytes are ignored.
- R11: After reset the page and column are 0, the machine is in `ST_IDLE`, and `dout_en` is 0.
- R12: Each completed access takes exactly one `ST_COMMIT` cycle, entered on the first clock after the strobe ends, and always followed by `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus68 | input | 1 | Bus flavour: 1 enable plus read/write, 0 separate strobes |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| dc | input | 1 | 1 display data, 0 command or status |
| rd_e | input | 1 | Read strobe (active low) or enable (active high) |
| wr_rw | input | 1 | Write strobe (active low) or read/write level |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data: holder for data reads, status byte otherwise |
| dout_en | output | 1 | High while the port should drive the host bus |

## Verification
The bench aims at the read pipeline. It checks the dummy read after address commands and after writes, where a design without the holder would return the addressed byte one read early. It drives the column into FFh to catch a pointer that wraps to 00h or bumps the page, which would corrupt column 0 or another page. It writes all-ones to the indicator page and checks for stray upper bits, sends out-of-range page numbers that a naive decoder would accept, and strobes while deselected to catch a port that honours strobes without a chip select.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } acc_state_t;

    typedef enum logic [1:0] {
        ACC_DRD  = 2'd0,
        ACC_DWR  = 2'd1,
        ACC_STAT = 2'd2,
        ACC_CMD  = 2'd3
    } acc_kind_t;

    function automatic acc_kind_t classify(input logic dc, input logic is_read);
        if (dc) return is_read ? ACC_DRD : ACC_DWR;
        return is_read ? ACC_STAT : ACC_CMD;
    endfunction

endpackage

// File: rtl/lcdp_bus_decode.sv
module lcdp_bus_decode (
    input  logic bus68,
    input  logic cs1_n,
    input  logic cs2,
    input  logic rd_e,
    input  logic wr_rw,
    output logic sel,
    output logic strobe,
    output logic is_read,
    output logic drive_en
);
    always_comb begin
        sel = !cs1_n && cs2;
        if (bus68) begin
            strobe  = rd_e;
            is_read = wr_rw;
        end else begin
            strobe  = !rd_e || !wr_rw;
            is_read = !rd_e;
        end
        drive_en = sel && strobe && is_read;
    end
endmodule

// File: rtl/lcdp_page_store.sv
module lcdp_page_store #(
    parameter int COLS  = 256,
    parameter int PAGES = 8,
    parameter int DW    = 8,
    localparam int CAW  = $clog2(COLS),
    localparam int PAW  = $clog2(PAGES + 1),
    localparam int FPW  = $clog2(PAGES)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [PAW-1:0] page,
    input  logic [CAW-1:0] col,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);
    logic [DW-1:0] page_rd [PAGES];
    logic          ind_mem [COLS];

    for (genvar g = 0; g < PAGES; g++) begin : g_page
        logic [DW-1:0] mem [COLS];
        always_ff @(posedge clk) begin
            if (we && page == PAW'(g)) mem[col] <= wdata;
        end
        assign page_rd[g] = mem[col];
    end

    always_ff @(posedge clk) begin
        if (we && page == PAW'(PAGES)) ind_mem[col] <= wdata[0];
    end

    always_comb begin
        if (page == PAW'(PAGES)) rdata = {{(DW-1){1'b0}}, ind_mem[col]};
        else                     rdata = page_rd[page[FPW-1:0]];
    end
endmodule

// File: rtl/lcdp_access_fsm.sv
module lcdp_access_fsm
    import lcdp_pkg::*;
#(
    parameter int COLS  = 256,
    parameter int PAGES = 8,
    parameter int DW    = 8,
    localparam int CAW  = $clog2(COLS),
    localparam int PAW  = $clog2(PAGES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           strobe,
    input  logic           is_read,
    input  logic           dc,
    input  logic [DW-1:0]  din,
    input  logic [DW-1:0]  rdata,
    output acc_state_t     state,
    output logic           mem_we,
    output logic [DW-1:0]  wdata,
    output logic [PAW-1:0] page,
    output logic [CAW-1:0] col,
    output logic [DW-1:0]  holder,
    output logic           busy,
    output logic           commit_data
);
    acc_state_t nxt;
    acc_kind_t  kind_q;
    logic [DW-1:0] data_q;
    logic ld_holder, col_step, cmd_go, capture;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (sel && strobe) nxt = ST_ACTIVE;
            ST_ACTIVE: if (!sel) nxt = ST_IDLE;
                       else if (!strobe) nxt = ST_COMMIT;
            ST_COMMIT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        capture     = sel && strobe && (state == ST_IDLE || state == ST_ACTIVE);
        busy        = (state == ST_COMMIT);
        mem_we      = busy && kind_q == ACC_DWR;
        ld_holder   = busy && kind_q == ACC_DRD;
        cmd_go      = busy && kind_q == ACC_CMD;
        col_step    = mem_we || ld_holder;
        commit_data = col_step;
        wdata       = data_q;
    end

    // bus capture: the last value seen while the strobe is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= ACC_STAT;
            data_q <= '0;
        end else if (capture) begin
            kind_q <= classify(dc, is_read);
            data_q <= din;
        end
    end

    // address registers and read holder
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page   <= '0;
            col    <= '0;
            holder <= '0;
        end else begin
            if (ld_holder) holder <= rdata;
            if (col_step && col != CAW'(COLS - 1)) col <= col + 1'b1;
            if (cmd_go) begin
                unique case (data_q[7:4])
                    4'hB: if (data_q[3:0] <= 4'(PAGES)) page <= PAW'(data_q[3:0]);
                    4'h1: col[CAW-1:4] <= data_q[CAW-5:0];
                    4'h0: col[3:0] <= data_q[3:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcdp_access_port.sv
module lcdp_access_port
    import lcdp_pkg::*;
#(
    parameter int COLS  = 256,
    parameter int PAGES = 8,
    parameter int DW    = 8,
    localparam int CAW  = $clog2(COLS),
    localparam int PAW  = $clog2(PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus68,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          dc,
    input  logic          rd_e,
    input  logic          wr_rw,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    logic sel, strobe, is_read, drive_en;
    logic mem_we, busy, commit_data;
    logic [DW-1:0] wdata, rdata, holder;
    logic [PAW-1:0] page_q;
    logic [CAW-1:0] col_q;
    acc_state_t state;

    lcdp_bus_decode u_dec (
        .bus68(bus68), .cs1_n(cs1_n), .cs2(cs2), .rd_e(rd_e), .wr_rw(wr_rw),
        .sel(sel), .strobe(strobe), .is_read(is_read), .drive_en(drive_en)
    );

    lcdp_access_fsm #(.COLS(COLS), .PAGES(PAGES), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel), .strobe(strobe), .is_read(is_read),
        .dc(dc), .din(din), .rdata(rdata), .state(state), .mem_we(mem_we),
        .wdata(wdata), .page(page_q), .col(col_q), .holder(holder),
        .busy(busy), .commit_data(commit_data)
    );

    lcdp_page_store #(.COLS(COLS), .PAGES(PAGES), .DW(DW)) u_store (
        .clk(clk), .we(mem_we), .page(page_q), .col(col_q),
        .wdata(wdata), .rdata(rdata)
    );

    always_comb begin
        dout_en = drive_en;
        dout    = dc ? holder : {busy, {(DW-1){1'b0}}};
    end
endmodule

// File: rtl/lcdp_access_port_chk.sv
module lcdp_access_port_chk
    import lcdp_pkg::*;
#(
    parameter int CAW   = 8,
    parameter int PAW   = 4,
    parameter int COLS  = 256,
    parameter int PAGES = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs1_n,
    input logic           cs2,
    input logic           dout_en,
    input acc_state_t     state,
    input logic [PAW-1:0] page,
    input logic [CAW-1:0] col,
    input logic           commit_data
);
    a_r3_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs1_n && cs2) |-> !dout_en);

    a_r12_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COMMIT |=> state == ST_IDLE);

    a_r6_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        commit_data && col != CAW'(COLS - 1) |=> col == $past(col) + 1'b1);

    a_r6_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
        commit_data && col == CAW'(COLS - 1) |=> col == CAW'(COLS - 1));

    a_r7_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        commit_data |=> $stable(page));

    a_r10_page_range: assert property (@(posedge clk) disable iff (!rst_n)
        page <= PAW'(PAGES));
endmodule

bind lcdp_access_port lcdp_access_port_chk #(
    .CAW(CAW), .PAW(PAW), .COLS(COLS), .PAGES(PAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .dout_en(dout_en),
    .state(state), .page(page_q), .col(col_q), .commit_data(commit_data)
);

// File: tb/lcdp_access_port_bench.sv
module lcdp_access_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus68 = 1'b0, cs1_n = 1'b1, cs2 = 1'b1, dc = 1'b0;
    logic rd_e = 1'b1, wr_rw = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lcdp_access_port u_lcdp_access_port (
        .clk(clk), .rst_n(rst_n), .bus68(bus68), .cs1_n(cs1_n), .cs2(cs2),
        .dc(dc), .rd_e(rd_e), .wr_rw(wr_rw), .din(din), .dout(dout),
        .dout_en(dout_en)
    );

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb_q[$];
    event sample_ev;

    // reference model of the requirements
    logic [7:0] m_mem [0:8][0:255];
    int m_page = 0, m_col = 0;
    logic [7:0] m_holder = 8'h00;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops expected reads and compares at sample points
    initial begin
        forever begin
            @(sample_ev);
            if (sb_q.size() == 0) begin
                check("scoreboard empty", 8'h00, 8'h01);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, dout, e.val);
                check({e.tag, " drive"}, {7'b0, dout_en}, 8'h01);
            end
        end
    end

    task automatic m_step();
        if (m_col != 255) m_col++;
    endtask

    task automatic m_apply(input bit rd, input bit dcv, input logic [7:0] d);
        if (dcv && !rd) begin
            m_mem[m_page][m_col] = (m_page == 8) ? {7'b0, d[0]} : d;
            m_step();
        end else if (dcv && rd) begin
            m_holder = m_mem[m_page][m_col];
            m_step();
        end else if (!rd) begin
            if (d[7:4] == 4'hB && d[3:0] <= 4'd8) m_page = int'(d[3:0]);
            else if (d[7:4] == 4'h1) m_col = (m_col & 15) | (int'(d[3:0]) << 4);
            else if (d[7:4] == 4'h0) m_col = (m_col & 240) | int'(d[3:0]);
        end
    endtask

    task automatic set_strobe(input bit rd, input bit on);
        if (bus68) begin
            wr_rw = rd;
            rd_e  = on;
        end else begin
            rd_e  = !(on && rd);
            wr_rw = !(on && !rd);
        end
    endtask

    // driver: one host access; selected accesses update the model
    task automatic access(input bit rd, input bit dcv, input logic [7:0] d,
                          input bit sel, input string tag);
        @(negedge clk);
        cs1_n = !sel;
        cs2   = 1'b1;
        dc    = dcv;
        din   = d;
        if (bus68) wr_rw = rd;
        @(negedge clk);
        set_strobe(rd, 1'b1);
        repeat (3) @(negedge clk);
        if (rd && sel) begin
            exp_t e;
            e.val = dcv ? m_holder : 8'h00;
            e.tag = tag;
            sb_q.push_back(e);
            -> sample_ev;
        end
        if (rd && !sel) check({tag, " no drive"}, {7'b0, dout_en}, 8'h00);
        @(negedge clk);
        set_strobe(rd, 1'b0);
        repeat (3) @(negedge clk);
        cs1_n = 1'b1;
        if (sel) m_apply(rd, dcv, d);
    endtask

    task automatic wr_data(input logic [7:0] d);
        access(1'b0, 1'b1, d, 1'b1, "R4 write");
    endtask
    task automatic cmd(input logic [7:0] d);
        access(1'b0, 1'b0, d, 1'b1, "R10 cmd");
    endtask
    task automatic rd_data(input string tag);
        access(1'b1, 1'b1, 8'h00, 1'b1, tag);
    endtask
    task automatic set_col(input logic [7:0] c);
        cmd({4'h1, c[7:4]});
        cmd({4'h0, c[3:0]});
    endtask

    initial begin
        for (int p = 0; p < 9; p++)
            for (int c = 0; c < 256; c++) m_mem[p][c] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 dout_en after reset", {7'b0, dout_en}, 8'h00);
        // R9 / R2: idle status read
        access(1'b1, 1'b0, 8'h00, 1'b1, "R9 status idle");

        // R2, R4, R5: separate-strobe writes then pipelined reads
        cmd(8'hB2);
        set_col(8'h10);
        wr_data(8'hA1); wr_data(8'hA2); wr_data(8'hA3);
        set_col(8'h10);
        rd_data("R5 dummy after column set");
        rd_data("R5 first real read");
        rd_data("R2 data read");

        // R6: saturation at FFh
        set_col(8'hFE);
        wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
        set_col(8'hFE);
        rd_data("R5 dummy after saturate");
        rd_data("R6 byte at FEh");
        rd_data("R6 overwritten FFh");
        rd_data("R6 held at FFh");
        // R7: page unchanged after hitting the end
        set_col(8'h10);
        rd_data("R7 dummy");
        rd_data("R7 page still 2");

        // R8: indicator page
        cmd(8'hB8);
        set_col(8'h05);
        wr_data(8'hFF); wr_data(8'hAE);
        set_col(8'h05);
        rd_data("R8 dummy");
        rd_data("R8 only bit0 kept");

        // R10: out-of-range page ignored
        cmd(8'hBC);
        cmd(8'h7E);
        set_col(8'h05);
        rd_data("R10 dummy");
        rd_data("R10 page stays 8");

        // R3: strobes while deselected
        cmd(8'hB2);
        set_col(8'h10);
        access(1'b0, 1'b1, 8'h5A, 1'b0, "R3 write unselected");
        access(1'b0, 1'b0, 8'h14, 1'b0, "R3 cmd unselected");
        access(1'b1, 1'b1, 8'h00, 1'b0, "R3 read unselected");
        rd_data("R3 dummy");
        rd_data("R3 memory untouched");

        // R1: enable plus read/write bus
        @(negedge clk);
        bus68 = 1'b1;
        rd_e  = 1'b0;
        wr_rw = 1'b1;
        cmd(8'hB3);
        set_col(8'h20);
        wr_data(8'hC1); wr_data(8'hC2); wr_data(8'hC3);
        set_col(8'h20);
        rd_data("R1 dummy enable mode");
        rd_data("R1 read enable mode");
        rd_data("R1 second read enable mode");
        access(1'b1, 1'b0, 8'h00, 1'b1, "R9 status enable mode");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) check("scoreboard drained", 8'(sb_q.size()), 8'h00);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule